// File: doc/BRIEF.md
# Prescaled Watchdog Timer

This block is a register-mapped watchdog for a single clock domain. A 16-bit down-counter is stepped by a tick strobe from a two-stage divider chain. The first stage is an 8-bit programmable prescaler that divides by P+1. The second stage is a fixed power-of-two divider that divides by 16, 32, 64 or 128. Nothing in the block runs on a derived clock. Every register advances on the system clock, and the counter moves only in a cycle where the tick strobe is high.

Software programs a reload value and loads the count. It then sets the control word with the run bit. While the timer runs, software must keep writing the count register. This refill is the keepalive. If the counter is stepped while it already holds zero, it expires. On expiry it refills itself from the reload register and emits a one-cycle pulse on the reset-request output, the interrupt output, or both, as two separate enables select.

Bus accesses are single-cycle. A write is taken on the clock edge where the write strobe is high. Read data is a combinational view of the addressed register.

Top module: `wdog_timer`

## Requirements
- R1: After reset, the control register reads 0xFF39, the reload and count registers both read 0x8000, and both request outputs are low.
- R2: The register map is as follows. Address 0 is control, address 1 is the reload value and address 2 is the current count. Address 3 reads zero and ignores writes. The control fields are:
  - prescaler P in bits [15:8]
  - run in bit 5
  - divider select in bits [4:3]
  - interrupt enable in bit 2
  - reset enable in bit 0

  Bits 7, 6 and 1 read zero.
- R3: While run is set, ticks occur every (P+1)*D clock cycles. D is 16, 32, 64 or 128 for divider select 00, 01, 10 or 11. Each tick lowers a nonzero count by exactly one.
- R4: A tick that finds the count at zero is an expiry, and the counter refills from the reload register. With reload value N, consecutive expiries are (N+1)*(P+1)*D cycles apart.
- R5: A write to the count register loads the written value at that clock edge, and the value reads back on the next cycle. Such a write takes priority over a tick in the same cycle. Repeated writes made more often than the expiry period prevent any expiry.
- R6: With reset enable set, each expiry raises the reset request for exactly one cycle.
- R7: With interrupt enable set and reset enable clear, each expiry raises only the interrupt output, for one cycle, and the reset request stays low.
- R8: With both enables set, each expiry pulses both outputs in the same cycle.
- R9: With run and reset enable both clear, the count holds its value and neither output pulses.
- R10: A write to the reload register does not change the current count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 2 | Register address |
| bus_wr | input | 1 | Write strobe, taken on the rising clock edge |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data of the addressed register (combinational) |
| rst_req | output | 1 | One-cycle system reset request on expiry |
| irq_req | output | 1 | One-cycle interrupt request on expiry |

## Verification
The divider chain is hidden, but it shows at the ports: a wrong prescaler or divider count changes the spacing between expiry pulses. It also changes the one-step decrement seen when the count register is read one tick period apart, and both symptoms appear within a single period. A corrupted count or a lost refill changes the next expiry interval. A stray or stuck pulse register shows up as a pulse wider than one cycle, or as a pulse on the wrong output, on the very next expiry. Frozen and keepalive states are checked by reading the count and watching both outputs over windows several periods long.

// File: rtl/wdog_pkg.sv
package wdog_pkg;

    localparam int BUS_W  = 16;
    localparam int CNT_W  = 16;
    localparam int PRE_W  = 8;
    localparam int DSEL_W = 2;
    localparam int ADDR_W = 2;

    localparam logic [ADDR_W-1:0] ADDR_CTRL   = 2'd0;
    localparam logic [ADDR_W-1:0] ADDR_RELOAD = 2'd1;
    localparam logic [ADDR_W-1:0] ADDR_COUNT  = 2'd2;

    localparam logic [CNT_W-1:0] COUNT_RST = 16'h8000;

    typedef struct packed {
        logic [PRE_W-1:0]  pre;
        logic              run;
        logic [DSEL_W-1:0] dsel;
        logic              irq_en;
        logic              rst_en;
    } ctrl_t;

    localparam ctrl_t CTRL_RST = '{pre: '1, run: 1'b1, dsel: '1, irq_en: 1'b0, rst_en: 1'b1};

    function automatic logic [BUS_W-1:0] ctrl_to_word(input ctrl_t c);
        return {c.pre, 2'b00, c.run, c.dsel, c.irq_en, 1'b0, c.rst_en};
    endfunction

    function automatic ctrl_t word_to_ctrl(input logic [BUS_W-1:0] w);
        ctrl_t c;
        c.pre    = w[15:8];
        c.run    = w[5];
        c.dsel   = w[4:3];
        c.irq_en = w[2];
        c.rst_en = w[0];
        return c;
    endfunction

endpackage

// File: rtl/wdog_tick_gen.sv
module wdog_tick_gen #(
    parameter int PRE_W        = 8,
    parameter int DSEL_W       = 2,
    parameter int DIV_BASE_LOG = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              run,
    input  logic [PRE_W-1:0]  pre,
    input  logic [DSEL_W-1:0] dsel,
    output logic              tick
);
    localparam int DIV_CW = DIV_BASE_LOG + (1 << DSEL_W) - 1;
    localparam int SH_W   = $clog2(DIV_CW + 1);

    typedef struct packed {
        logic [PRE_W-1:0]  pre_cnt;
        logic [DIV_CW-1:0] div_cnt;
    } tg_state_t;

    tg_state_t st_d, st_q;
    logic            pre_hit;
    logic [SH_W-1:0] shamt;
    logic [DIV_CW:0] div_lim_w;
    logic [DIV_CW-1:0] div_lim;

    always_comb begin
        shamt     = SH_W'(DIV_BASE_LOG) + SH_W'(dsel);
        div_lim_w = ({{DIV_CW{1'b0}}, 1'b1} << shamt) - {{DIV_CW{1'b0}}, 1'b1};
        div_lim   = div_lim_w[DIV_CW-1:0];
        pre_hit   = run && (st_q.pre_cnt >= pre);
        tick      = pre_hit && (st_q.div_cnt >= div_lim);
        st_d      = st_q;
        if (!run) begin
            st_d.pre_cnt = '0;
            st_d.div_cnt = '0;
        end else if (pre_hit) begin
            st_d.pre_cnt = '0;
            st_d.div_cnt = tick ? '0 : st_q.div_cnt + DIV_CW'(1);
        end else begin
            st_d.pre_cnt = st_q.pre_cnt + PRE_W'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    // R3: the fixed stage divides by at least 16, so ticks never come back to back
    a_r3_tick_gap: assert property (@(posedge clk) disable iff (!rst_n)
        tick |=> !tick);

    // R9: a stopped chain keeps its counters cleared
    a_r9_idle_clear: assert property (@(posedge clk) disable iff (!rst_n)
        !run |=> (st_q.pre_cnt == '0 && st_q.div_cnt == '0));

endmodule

// File: rtl/wdog_down_cnt.sv
module wdog_down_cnt #(
    parameter int              CNT_W   = 16,
    parameter logic [CNT_W-1:0] RST_VAL = 16'h8000
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    input  logic [CNT_W-1:0] reload_val,
    input  logic             irq_en,
    input  logic             rst_en,
    output logic [CNT_W-1:0] count,
    output logic             irq_req,
    output logic             rst_req
);
    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic             irq;
        logic             rst;
    } dc_state_t;

    dc_state_t st_d, st_q;
    logic      expire;

    always_comb begin
        expire = tick && !load && (st_q.cnt == '0);
        st_d   = st_q;
        if (load)
            st_d.cnt = load_val;
        else if (tick)
            st_d.cnt = (st_q.cnt == '0) ? reload_val : st_q.cnt - CNT_W'(1);
        st_d.irq = expire && irq_en;
        st_d.rst = expire && rst_en;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '{cnt: RST_VAL, irq: 1'b0, rst: 1'b0};
        else        st_q <= st_d;
    end

    assign count   = st_q.cnt;
    assign irq_req = st_q.irq;
    assign rst_req = st_q.rst;

    // R5: a count write lands on the next edge, ahead of any tick
    a_r5_load_now: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> count == $past(load_val));

    // R3: one step down per tick
    a_r3_step: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && !load && count != '0) |=> count == $past(count) - CNT_W'(1));

    // R4: refill on expiry
    a_r4_refill: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && !load && count == '0) |=> count == $past(reload_val));

    // R9: without tick or load the count holds
    a_r9_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!tick && !load) |=> $stable(count));

    // R6: reset request is a single-cycle pulse gated by its enable
    a_r6_rst_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        rst_req |-> ($past(rst_en) && $past(tick)) ##1 !rst_req);

    // R7: interrupt is a single-cycle pulse gated by its enable
    a_r7_irq_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        irq_req |-> ($past(irq_en) && $past(tick)) ##1 !irq_req);

endmodule

// File: rtl/wdog_timer.sv
module wdog_timer
    import wdog_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr,
    input  logic [BUS_W-1:0]  bus_wdata,
    output logic [BUS_W-1:0]  bus_rdata,
    output logic              rst_req,
    output logic              irq_req
);
    typedef struct packed {
        ctrl_t            ctrl;
        logic [CNT_W-1:0] reload;
    } regs_t;

    regs_t            rg_d, rg_q;
    logic             tick;
    logic             cnt_load;
    logic [CNT_W-1:0] count;

    always_comb begin
        rg_d     = rg_q;
        cnt_load = bus_wr && (bus_addr == ADDR_COUNT);
        if (bus_wr && bus_addr == ADDR_CTRL)
            rg_d.ctrl = word_to_ctrl(bus_wdata);
        if (bus_wr && bus_addr == ADDR_RELOAD)
            rg_d.reload = bus_wdata[CNT_W-1:0];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) rg_q <= '{ctrl: CTRL_RST, reload: COUNT_RST};
        else        rg_q <= rg_d;
    end

    always_comb begin
        case (bus_addr)
            ADDR_CTRL:   bus_rdata = ctrl_to_word(rg_q.ctrl);
            ADDR_RELOAD: bus_rdata = BUS_W'(rg_q.reload);
            ADDR_COUNT:  bus_rdata = BUS_W'(count);
            default:     bus_rdata = '0;
        endcase
    end

    wdog_tick_gen #(
        .PRE_W        (PRE_W),
        .DSEL_W       (DSEL_W),
        .DIV_BASE_LOG (4)
    ) u_tick (
        .clk   (clk),
        .rst_n (rst_n),
        .run   (rg_q.ctrl.run),
        .pre   (rg_q.ctrl.pre),
        .dsel  (rg_q.ctrl.dsel),
        .tick  (tick)
    );

    wdog_down_cnt #(
        .CNT_W   (CNT_W),
        .RST_VAL (COUNT_RST)
    ) u_cnt (
        .clk        (clk),
        .rst_n      (rst_n),
        .tick       (tick),
        .load       (cnt_load),
        .load_val   (bus_wdata[CNT_W-1:0]),
        .reload_val (rg_q.reload),
        .irq_en     (rg_q.ctrl.irq_en),
        .rst_en     (rg_q.ctrl.rst_en),
        .count      (count),
        .irq_req    (irq_req),
        .rst_req    (rst_req)
    );

    // R2: a control write is taken field by field
    a_r2_ctrl_write: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == ADDR_CTRL) |=> rg_q.ctrl == word_to_ctrl($past(bus_wdata)));

    // R10: a reload write alone leaves the reload path to the count untouched
    a_r10_reload_only: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == ADDR_RELOAD && !tick) |=> $stable(count));

    // R8: with both enables, the two pulses coincide
    a_r8_both_same: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rg_q.ctrl.irq_en) && $past(rg_q.ctrl.rst_en)) |-> (irq_req == rst_req));

endmodule

// File: tb/wdog_timer_tb.sv
module wdog_timer_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [1:0]  bus_addr = '0;
    logic        bus_wr = 1'b0;
    logic [15:0] bus_wdata = '0;
    logic [15:0] bus_rdata;
    logic        rst_req, irq_req;

    int n_chk = 0, n_fail = 0;
    int cyc = 0;
    int irq_n = 0, rst_n_cnt = 0;
    int irq_t0 = 0, irq_t1 = 0, rst_t0 = 0, rst_t1 = 0;
    int wide_err = 0;
    logic irq_prev = 1'b0, rst_prev = 1'b0;
    bit done = 0;

    always #5 clk = ~clk;

    wdog_timer u_dut (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .rst_req(rst_req), .irq_req(irq_req)
    );

    always @(posedge clk) cyc <= cyc + 1;

    always @(negedge clk) begin
        if (irq_req) begin
            if (irq_prev) wide_err++;
            irq_n++; irq_t0 = irq_t1; irq_t1 = cyc;
        end
        if (rst_req) begin
            if (rst_prev) wide_err++;
            rst_n_cnt++; rst_t0 = rst_t1; rst_t1 = cyc;
        end
        irq_prev = irq_req;
        rst_prev = rst_req;
    end

    task automatic chk(input string tag, input int act, input int exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [15:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [15:0] d);
        @(negedge clk);
        bus_addr = a;
        #1 d = bus_rdata;
    endtask

    task automatic clr_mon();
        irq_n = 0; rst_n_cnt = 0; wide_err = 0;
    endtask

    task automatic t_reset();
        logic [15:0] v;
        chk("R1 rst_req after reset", int'(rst_req), 0);
        chk("R1 irq_req after reset", int'(irq_req), 0);
        rd(2'd0, v); chk("R1 control reset", int'(v), 'hFF39);
        rd(2'd1, v); chk("R1 reload reset", int'(v), 'h8000);
        rd(2'd2, v); chk("R1 count reset", int'(v), 'h8000);
    endtask

    task automatic t_regmap();
        logic [15:0] v;
        wr(2'd0, 16'hA5DE);
        rd(2'd0, v); chk("R2 control fields, unused bits zero", int'(v), 'hA51C);
        wr(2'd3, 16'h1234);
        rd(2'd3, v); chk("R2 address 3 reads zero", int'(v), 0);
        rd(2'd0, v); chk("R2 address 3 write ignored", int'(v), 'hA51C);
        wr(2'd2, 16'h0042);
        rd(2'd2, v); chk("R5 count write loads", int'(v), 'h0042);
        wr(2'd1, 16'h0123);
        rd(2'd1, v); chk("R2 reload readback", int'(v), 'h0123);
        rd(2'd2, v); chk("R10 reload write keeps count", int'(v), 'h0042);
    endtask

    task automatic t_step(input logic [15:0] ctrl, input int period, input string tag);
        logic [15:0] c0, c1;
        wr(2'd0, 16'h0000);
        wr(2'd1, 16'h0100);
        wr(2'd2, 16'h0100);
        wr(2'd0, ctrl);
        repeat (3 * period) @(negedge clk);
        rd(2'd2, c0);
        repeat (period - 1) @(negedge clk);
        rd(2'd2, c1);
        chk(tag, int'(c0) - int'(c1), 1);
    endtask

    task automatic t_mode(input logic [15:0] ctrl, input logic [15:0] n, input int exp_int,
                          input bit want_irq, input bit want_rst, input string tag);
        wr(2'd0, 16'h0000);
        wr(2'd1, n);
        wr(2'd2, n);
        clr_mon();
        wr(2'd0, ctrl);
        for (int i = 0; i < 4000 && irq_n < 2 && rst_n_cnt < 2; i++) @(negedge clk);
        @(negedge clk);
        if (want_irq) chk({tag, " R4 irq interval"}, irq_t1 - irq_t0, exp_int);
        else          chk({tag, " R7 irq silent"}, irq_n, 0);
        if (want_rst) chk({tag, " R6 rst interval"}, rst_t1 - rst_t0, exp_int);
        else          chk({tag, " R7 rst silent"}, rst_n_cnt, 0);
        if (want_irq && want_rst) chk({tag, " R8 same cycle"}, irq_t1, rst_t1);
        chk({tag, " R6 single-cycle pulses"}, wide_err, 0);
    endtask

    task automatic t_keepalive();
        wr(2'd0, 16'h0000);
        wr(2'd1, 16'h0003);
        wr(2'd2, 16'h0003);
        clr_mon();
        wr(2'd0, 16'h0025);
        for (int k = 0; k < 10; k++) begin
            repeat (40) @(negedge clk);
            wr(2'd2, 16'h0003);
        end
        chk("R5 keepalive holds off irq", irq_n, 0);
        chk("R5 keepalive holds off rst", rst_n_cnt, 0);
        repeat (100) @(negedge clk);
        chk("R5 expiry once refills stop", irq_n, 1);
    endtask

    task automatic t_stop();
        logic [15:0] c0, c1, v;
        wr(2'd0, 16'h0004);
        clr_mon();
        rd(2'd2, c0);
        repeat (300) @(negedge clk);
        rd(2'd2, c1);
        chk("R9 stopped count holds", int'(c1), int'(c0));
        chk("R9 no pulses when stopped", irq_n + rst_n_cnt, 0);
        wr(2'd1, 16'h0777);
        rd(2'd2, v); chk("R10 count unchanged by reload write", int'(v), int'(c0));
        rd(2'd1, v); chk("R10 reload written", int'(v), 'h0777);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_regmap();
        t_step(16'h0024, 16, "R3 P=0 D=16 step");
        t_step(16'h0124, 32, "R3 P=1 D=16 step");
        t_step(16'h002C, 32, "R3 P=0 D=32 step");
        t_step(16'h0034, 64, "R3 P=0 D=64 step");
        t_mode(16'h0024, 16'h0002, 48,  1'b1, 1'b0, "R7 irq only");
        t_mode(16'h0129, 16'h0001, 128, 1'b0, 1'b1, "R6 rst only");
        t_mode(16'h0335, 16'h0000, 256, 1'b1, 1'b1, "R8 both");
        t_mode(16'h003C, 16'h0001, 256, 1'b1, 1'b0, "R4 D=128");
        t_keepalive();
        t_stop();
        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog expired actual=hung expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
            $finish;
        end
    end
endmodule